// File: doc/BRIEF.md
# Host-to-Blitter Data Port Sequencer

This block sits between the host bus and the pixel stage of a rectangle-fill engine. The host loads an operation setup: width, height, pixel size, horizontal direction and a start strobe. It then streams the source pixels by writing into a memory-mapped data aperture. Port writes may be one, two or four bytes wide. The block breaks them into single bytes and gathers the bytes into whole pixels of one to four bytes.

Each finished pixel goes to the downstream pixel processor as a one-cycle pulse, together with the destination column and row it belongs to. The block walks that position across the rectangle. After the last row it stops taking data and raises a sticky completion interrupt, which the host clears with an acknowledge.

Top module: `blit_hostport`

## Requirements
- R1: A host write reaches the data port only when address bit 16 is set. A write with bit 16 clear leaves the byte stream, the pixel output and the position unchanged.
- R2: Write size is encoded on `host_wsize` as 0 = one byte, 1 = two bytes and 2 or 3 = four bytes. The bytes of a write are pushed one per cycle, starting with bits 7:0 and rising by lane. `host_ready` is high in reset and whenever at most one byte of the previous write is still waiting.
- R3: Bytes that reach the port while no operation is running are discarded and produce no pixel.
- R4: When `cfg_size_ovr` is 1 the pixel size in bytes is `cfg_size_code`+1. When it is 0 the pixel size is the parameter default, which is one byte.
- R5: Pixel bytes are packed little-endian: the k-th byte of a pixel lands in bits 8k+7:8k. Bytes above the pixel size are zero.
- R6: Each start strobe empties any partly gathered pixel, so the first pixel of the new operation is built only from bytes that arrive after the strobe.
- R7: `pix_valid` is high for exactly one cycle, in the cycle after the final byte of a pixel is consumed. It carries the pixel's data and the x and y that held before that pixel advanced the position.
- R8: After each pixel the column count increments and x moves by one, up when the direction flag is 0 and down when it is 1. When the column count reaches the width, the column count clears and y increments by one, starting from y = 0.
- R9: At the start of every row, the first row included, x is width-1 when `cfg_xrev` is 1 and 0 otherwise.
- R10: Once the row count exceeds `cfg_height`, after height+1 rows, `busy` drops and `irq_done` rises. Later port bytes give no pixels.
- R11: `irq_done` stays set until `irq_ack` is high at a clock edge. A completion in the same cycle as the acknowledge leaves it set. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW (17) | Host write address; bit 16 selects the data port |
| host_wdata | input | 32 | Host write data |
| host_wsize | input | 2 | Write size: 0 byte, 1 halfword, 2/3 word |
| host_ready | output | 1 | Port can take a new write this cycle |
| cfg_start | input | 1 | Start strobe; latches the setup below |
| cfg_width | input | XW (12) | Columns per row |
| cfg_height | input | YW (12) | Last row index (height+1 rows) |
| cfg_size_ovr | input | 1 | Use `cfg_size_code` for pixel size |
| cfg_size_code | input | 2 | Pixel size minus one |
| cfg_xrev | input | 1 | Rows run from right to left |
| irq_ack | input | 1 | Clears the completion interrupt |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_data | output | 32 | Assembled pixel |
| pix_x | output | XW (12) | Destination column of the pixel |
| pix_y | output | YW (12) | Destination row of the pixel |
| busy | output | 1 | Operation running |
| irq_done | output | 1 | Sticky completion flag |

## Verification
The main flow runs under every pixel size, with byte, halfword and word writes. Some of these mixes let pixels straddle two host writes, and others pack several pixels into one write. Together they separate errors in lane order, in the byte count per pixel and in zeroing the unused upper bytes. Both direction settings and several widths and heights are used, so a wrong row reload, an off-by-one in the row end or an early finish shows up as misplaced x/y values or a wrong pixel count. Directed cases cover idle writes, writes outside the port, a restart that leaves a stale byte, writes after completion and the exact cycle of the pixel strobe.

// File: rtl/blit_hport_pkg.sv
package blit_hport_pkg;

  localparam int unsigned LANE_W   = 8;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned LANES    = BUS_W / LANE_W;
  localparam int unsigned LEFT_W   = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    WSZ_BYTE = 2'd0,
    WSZ_HALF = 2'd1,
    WSZ_WORD = 2'd2,
    WSZ_WALT = 2'd3
  } wsize_e;

  function automatic logic [LEFT_W-1:0] wsize_lanes(input logic [1:0] sz);
    case (wsize_e'(sz))
      WSZ_BYTE: return LEFT_W'(1);
      WSZ_HALF: return LEFT_W'(2);
      default:  return LEFT_W'(LANES);
    endcase
  endfunction

endpackage

// File: rtl/blit_rst_sync.sv
module blit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/blit_byte_splitter.sv
module blit_byte_splitter
  import blit_hport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BUS_W-1:0]  data,
  input  logic [1:0]        wsize,
  output logic              ready,
  output logic              byte_vld,
  output logic [LANE_W-1:0] byte_val
);
  logic [BUS_W-1:0]  sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              load;

  assign ready    = (left_q <= LEFT_W'(1));
  assign load     = push && ready;
  assign byte_vld = (left_q != '0);
  assign byte_val = sh_q[LANE_W-1:0];

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = data;
      left_d = wsize_lanes(wsize);
    end else if (byte_vld) begin
      sh_d   = {{LANE_W{1'b0}}, sh_q[BUS_W-1:LANE_W]};
      left_d = left_q - LEFT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  AST_SPLIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !load) |=> (left_q == $past(left_q) - LEFT_W'(1))); // R2
  AST_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q > LEFT_W'(1)) |=> (byte_val == $past(sh_q[2*LANE_W-1:LANE_W]))); // R2
endmodule

// File: rtl/blit_pixel_packer.sv
module blit_pixel_packer
  import blit_hport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take_en,
  input  logic              byte_vld,
  input  logic [LANE_W-1:0] byte_val,
  input  logic [1:0]        size_m1,
  output logic              pix_strobe,
  output logic [BUS_W-1:0]  pix_word
);
  logic [1:0]       cnt_q, cnt_d;
  logic [BUS_W-1:0] acc_q, acc_d;
  logic             take;
  logic [BUS_W-1:0] lane_word;

  assign take       = byte_vld && take_en;
  assign lane_word  = {{(BUS_W-LANE_W){1'b0}}, byte_val} << (LANE_W * cnt_q);
  assign pix_word   = acc_q | lane_word;
  assign pix_strobe = take && (cnt_q == size_m1);

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (clear) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (pix_strobe) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 2'd1;
      acc_d = pix_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt_q <= size_m1)); // R4
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == 2'd0)); // R6
endmodule

// File: rtl/blit_rect_walker.sv
module blit_rect_walker #(
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] width,
  input  logic [YW-1:0] height,
  input  logic          xrev,
  input  logic          step,
  input  logic          irq_ack,
  output logic          busy,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          irq
);
  logic [XW-1:0] w_q, w_d;
  logic [YW-1:0] h_q, h_d;
  logic          rev_q, rev_d;
  logic [XW-1:0] x_q, x_d, cx_q, cx_d;
  logic [YW-1:0] y_q, y_d;
  logic [YW:0]   cy_q, cy_d;
  logic          busy_q, busy_d, irq_q, irq_d, irq_set;
  logic [XW:0]   cx_inc;
  logic [YW:0]   cy_inc;
  logic [XW-1:0] row_x;

  assign cx_inc = {1'b0, cx_q} + (XW+1)'(1);
  assign cy_inc = cy_q + (YW+1)'(1);
  assign row_x  = rev_q ? (w_q - XW'(1)) : '0;

  always_comb begin
    w_d = w_q; h_d = h_q; rev_d = rev_q;
    x_d = x_q; y_d = y_q; cx_d = cx_q; cy_d = cy_q;
    busy_d = busy_q; irq_set = 1'b0;
    if (start) begin
      w_d = width; h_d = height; rev_d = xrev;
      x_d = xrev ? (width - XW'(1)) : '0;
      y_d = '0; cx_d = '0; cy_d = '0;
      busy_d = 1'b1;
    end else if (step && busy_q) begin
      if (cx_inc >= {1'b0, w_q}) begin
        cx_d = '0;
        cy_d = cy_inc;
        y_d  = y_q + YW'(1);
        x_d  = row_x;
        if (cy_inc > {1'b0, h_q}) begin
          busy_d  = 1'b0;
          irq_set = 1'b1;
        end
      end else begin
        cx_d = cx_inc[XW-1:0];
        x_d  = rev_q ? (x_q - XW'(1)) : (x_q + XW'(1));
      end
    end
    irq_d = irq_set ? 1'b1 : (irq_ack ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0; h_q <= '0; rev_q <= 1'b0;
      x_q <= '0; y_q <= '0; cx_q <= '0; cy_q <= '0;
      busy_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      w_q <= w_d; h_q <= h_d; rev_q <= rev_d;
      x_q <= x_d; y_q <= y_d; cx_q <= cx_d; cy_q <= cy_d;
      busy_q <= busy_d; irq_q <= irq_d;
    end
  end

  assign busy = busy_q;
  assign x    = x_q;
  assign y    = y_q;
  assign irq  = irq_q;

  AST_X_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && w_q != '0) |-> (x_q < w_q)); // R9
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step && !start && cx_inc >= {1'b0, w_q}) |=> (cx_q == '0)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q); // R11
  AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> irq_q); // R10
endmodule

// File: rtl/blit_hostport.sv
module blit_hostport
  import blit_hport_pkg::*;
#(
  parameter int unsigned AW         = 17,
  parameter int unsigned PORT_BIT   = 16,
  parameter int unsigned XW         = 12,
  parameter int unsigned YW         = 12,
  parameter int unsigned DFLT_BYTES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  input  logic [1:0]    host_wsize,
  output logic          host_ready,
  input  logic          cfg_start,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic          cfg_size_ovr,
  input  logic [1:0]    cfg_size_code,
  input  logic          cfg_xrev,
  input  logic          irq_ack,
  output logic          pix_valid,
  output logic [31:0]   pix_data,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          busy,
  output logic          irq_done
);
  localparam logic [1:0] DFLT_M1 = 2'(DFLT_BYTES - 1);

  logic              srst_n;
  logic              port_wr;
  logic              byte_vld, pix_strobe;
  logic [LANE_W-1:0] byte_val;
  logic [BUS_W-1:0]  pix_word;
  logic [1:0]        size_q, size_d;
  logic [XW-1:0]     cur_x;
  logic [YW-1:0]     cur_y;
  logic              pv_q, pv_d;
  logic [31:0]       pd_q, pd_d;
  logic [XW-1:0]     px_q, px_d;
  logic [YW-1:0]     py_q, py_d;

  assign port_wr = host_wr && host_addr[PORT_BIT];

  blit_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  blit_byte_splitter u_split (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (port_wr),
    .data     (host_wdata),
    .wsize    (host_wsize),
    .ready    (host_ready),
    .byte_vld (byte_vld),
    .byte_val (byte_val)
  );

  blit_pixel_packer u_pack (
    .clk        (clk),
    .rst_n      (srst_n),
    .clear      (cfg_start),
    .take_en    (busy),
    .byte_vld   (byte_vld),
    .byte_val   (byte_val),
    .size_m1    (size_q),
    .pix_strobe (pix_strobe),
    .pix_word   (pix_word)
  );

  blit_rect_walker #(.XW(XW), .YW(YW)) u_walk (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (cfg_start),
    .width   (cfg_width),
    .height  (cfg_height),
    .xrev    (cfg_xrev),
    .step    (pix_strobe),
    .irq_ack (irq_ack),
    .busy    (busy),
    .x       (cur_x),
    .y       (cur_y),
    .irq     (irq_done)
  );

  always_comb begin
    size_d = size_q;
    if (cfg_start) size_d = cfg_size_ovr ? cfg_size_code : DFLT_M1;
    pv_d = pix_strobe;
    pd_d = pd_q; px_d = px_q; py_d = py_q;
    if (pix_strobe) begin
      pd_d = pix_word;
      px_d = cur_x;
      py_d = cur_y;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      size_q <= DFLT_M1;
      pv_q   <= 1'b0;
      pd_q   <= '0;
      px_q   <= '0;
      py_q   <= '0;
    end else begin
      size_q <= size_d;
      pv_q   <= pv_d;
      pd_q   <= pd_d;
      px_q   <= px_d;
      py_q   <= py_d;
    end
  end

  assign pix_valid = pv_q;
  assign pix_data  = pd_q;
  assign pix_x     = px_q;
  assign pix_y     = py_q;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (pix_valid && size_q == 2'd0 && !$past(cfg_start)) |-> (pix_data[31:8] == 24'd0)); // R5
  AST_IDLE_NO_PIX: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && !cfg_start) |=> !pix_valid); // R3
endmodule

// File: tb/blit_hostport_tb.sv
module blit_hostport_tb;
  localparam int XW = 12;
  localparam int YW = 12;

  typedef struct packed {
    logic [7:0] w;
    logic [7:0] h;
    logic       ovr;
    logic [1:0] code;
    logic       rev;
    logic [1:0] wsz;
    logic [7:0] npix;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{w:8'd3, h:8'd1, ovr:1'b1, code:2'd0, rev:1'b0, wsz:2'd0, npix:8'd6},
    '{w:8'd2, h:8'd1, ovr:1'b1, code:2'd1, rev:1'b1, wsz:2'd1, npix:8'd4},
    '{w:8'd4, h:8'd0, ovr:1'b1, code:2'd3, rev:1'b0, wsz:2'd2, npix:8'd4},
    '{w:8'd2, h:8'd1, ovr:1'b1, code:2'd2, rev:1'b1, wsz:2'd2, npix:8'd4},
    '{w:8'd4, h:8'd0, ovr:1'b1, code:2'd0, rev:1'b1, wsz:2'd3, npix:8'd4},
    '{w:8'd2, h:8'd1, ovr:1'b0, code:2'd3, rev:1'b0, wsz:2'd1, npix:8'd4}
  };

  logic clk, rst_n;
  logic host_wr, host_ready, cfg_start, cfg_size_ovr, cfg_xrev, irq_ack;
  logic [16:0] host_addr;
  logic [31:0] host_wdata, pix_data;
  logic [1:0]  host_wsize, cfg_size_code;
  logic [XW-1:0] cfg_width, pix_x;
  logic [YW-1:0] cfg_height, pix_y;
  logic pix_valid, busy, irq_done;

  int checks = 0;
  int errors = 0;
  int sidx = 0;
  int lg_n = 0;
  bit finished = 0;
  logic [31:0]   lg_d [256];
  logic [XW-1:0] lg_x [256];
  logic [YW-1:0] lg_y [256];

  blit_hostport u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wsize(host_wsize), .host_ready(host_ready),
    .cfg_start(cfg_start), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_size_ovr(cfg_size_ovr), .cfg_size_code(cfg_size_code), .cfg_xrev(cfg_xrev),
    .irq_ack(irq_ack), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_x(pix_x), .pix_y(pix_y), .busy(busy), .irq_done(irq_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && pix_valid && lg_n < 256) begin
      lg_d[lg_n] = pix_data;
      lg_x[lg_n] = pix_x;
      lg_y[lg_n] = pix_y;
      lg_n++;
    end
  end

  function automatic logic [7:0] bval(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic port, input logic [31:0] d, input logic [1:0] sz);
    while (!host_ready) @(negedge clk);
    host_addr  = port ? 17'h10000 : 17'h00040;
    host_wdata = d;
    host_wsize = sz;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic start_op(input int w, input int h, input logic ovr, input logic [1:0] code, input logic rev);
    cfg_width = XW'(w); cfg_height = YW'(h);
    cfg_size_ovr = ovr; cfg_size_code = code; cfg_xrev = rev;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int base, s0, nbytes, wb, sz;
    logic [31:0] d, ex;
    rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0; host_wsize = '0;
    cfg_start = 1'b0; cfg_width = '0; cfg_height = '0; cfg_size_ovr = 1'b0;
    cfg_size_code = '0; cfg_xrev = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check(!busy && !pix_valid, "R10 reset idle", {busy, pix_valid}, 0);
    check(!irq_done, "R11 reset irq", irq_done, 0);
    check(host_ready, "R2 reset ready", host_ready, 1);

    // R3: writes while idle are dropped
    base = lg_n;
    host_write(1'b1, 32'h44332211, 2'd2);
    repeat (8) @(negedge clk);
    check(lg_n == base, "R3 idle bytes", lg_n - base, 0);

    // table-driven main flow
    for (int v = 0; v < NV; v++) begin
      sz = VECS[v].ovr ? int'(VECS[v].code) + 1 : 1;
      wb = (VECS[v].wsz == 2'd0) ? 1 : (VECS[v].wsz == 2'd1) ? 2 : 4;
      nbytes = int'(VECS[v].npix) * sz;
      start_op(int'(VECS[v].w), int'(VECS[v].h), VECS[v].ovr, VECS[v].code, VECS[v].rev);
      base = lg_n;
      s0 = sidx;
      for (int k = 0; k < nbytes; k += wb) begin
        d = {bval(sidx + 3), bval(sidx + 2), bval(sidx + 1), bval(sidx)};
        if (wb == 2) d[31:16] = 16'hDEAD;
        if (wb == 1) d[31:8]  = 24'hC0FFEE;
        host_write(1'b1, d, VECS[v].wsz);
        sidx += wb;
      end
      repeat (8) @(negedge clk);
      // R10: pixel count is width*(height+1)
      check(lg_n - base == int'(VECS[v].npix), "R10 pixel count", lg_n - base, VECS[v].npix);
      for (int p = 0; p < int'(VECS[v].npix); p++) begin
        int c, r, ex_x;
        ex = '0;
        for (int k = 0; k < sz; k++) ex |= 32'(bval(s0 + p * sz + k)) << (8 * k);
        c = p % int'(VECS[v].w);
        r = p / int'(VECS[v].w);
        ex_x = VECS[v].rev ? int'(VECS[v].w) - 1 - c : c;
        // R4 R5 R2: bytes and size; R8 R9: position
        check(lg_d[base + p] == ex, "R5 pixel data", lg_d[base + p], ex);
        check(lg_x[base + p] == XW'(ex_x) && lg_y[base + p] == YW'(r), "R8 R9 position",
              {lg_x[base + p], lg_y[base + p]}, {XW'(ex_x), YW'(r)});
      end
      check(!busy && irq_done, "R10 done flags", {busy, irq_done}, 1);
      // R10: bytes after completion give no pixel
      host_write(1'b1, 32'h99887766, 2'd2);
      repeat (6) @(negedge clk);
      check(lg_n - base == int'(VECS[v].npix), "R10 late bytes", lg_n - base, VECS[v].npix);
      check(irq_done, "R11 sticky", irq_done, 1);
      ack_irq();
      check(!irq_done, "R11 ack clears", irq_done, 0);
    end

    // R1: non-port address ignored while running
    start_op(1, 0, 1'b1, 2'd0, 1'b0);
    base = lg_n;
    host_write(1'b0, 32'h000000A5, 2'd0);
    repeat (4) @(negedge clk);
    check(lg_n == base && busy, "R1 non-port write", lg_n - base, 0);
    host_write(1'b1, 32'h0000005A, 2'd0);
    repeat (4) @(negedge clk);
    check(lg_n == base + 1 && lg_d[base] == 32'h5A, "R1 port write", lg_d[base], 32'h5A);
    ack_irq();

    // R6: restart discards partial pixel
    start_op(1, 0, 1'b1, 2'd3, 1'b0);
    host_write(1'b1, 32'h00000011, 2'd0);
    repeat (3) @(negedge clk);
    start_op(1, 0, 1'b1, 2'd1, 1'b0);
    base = lg_n;
    host_write(1'b1, 32'h1234BBAA, 2'd1);
    repeat (5) @(negedge clk);
    check(lg_n == base + 1 && lg_d[base] == 32'h0000BBAA, "R6 restart", lg_d[base], 32'h0000BBAA);
    ack_irq();

    // R7: strobe timing, one cycle wide, position before advance
    start_op(2, 0, 1'b1, 2'd0, 1'b0);
    host_write(1'b1, 32'h0000003C, 2'd0);
    check(!pix_valid, "R7 not yet", pix_valid, 0);
    @(negedge clk);
    check(pix_valid && pix_data == 32'h3C && pix_x == 0, "R7 strobe", {pix_valid, pix_data}, {1'b1, 32'h3C});
    @(negedge clk);
    check(!pix_valid, "R7 one cycle", pix_valid, 0);
    host_write(1'b1, 32'h0000003D, 2'd0);
    @(negedge clk);
    check(pix_valid && pix_x == 1, "R8 second column", pix_x, 1);
    repeat (3) @(negedge clk);
    ack_irq();

    finished = 1;
    summary();
    $finish;
  end
endmodule